// File: doc/BRIEF.md
# Streaming Glyph ROM Address Generator

This block turns CPU reads of a 4 KiB font window into addresses for an external character ROM. The low twelve address bits of a window access pick one glyph. A hidden 5-bit position counter picks one byte of that glyph's 32-byte record. Each read through the window moves the counter on by one, so software can fetch a whole glyph by reading the same address 32 times in a row.

A small register window sits beside the font window. One register serves two purposes. Reading it rewinds the position counter to zero. Writing it sets a page bit, which becomes the top bit of the ROM address. A second register holds one byte that the CPU can write. Bit 3 of that byte selects the graphics bank, and the byte clears itself to zero when the CPU reads it. Reads of any other address in the register window return all ones.

The ROM's data path is outside this block. The block supplies the address combinationally, together with a strobe that marks each window read. Register read data is also combinational, and every register update happens on the clock edge that ends the read or write strobe. The bus is assumed never to assert read and write in the same cycle.

Top module: `glyph_stream_reader`

## Requirements
- R1: Whenever bus_addr lies in 0x5000–0x5FFF, rom_addr equals {page, bus_addr[11:0], position}, so bits [4:0] carry the position and bits [16:5] carry the glyph index. rom_rd is 1 exactly when bus_rd is 1 and bus_addr lies in that window.
- R2: Every clock edge that ends a window read raises the position by one, modulo 32, so 31 wraps to 0.
- R3: A read of 0x40B0 returns 0x00 on rd_data and sets the position to 0 on the edge that ends the read.
- R4: A write to 0x40B0 stores data bit 0 as the page bit and ignores bits 7:1. The page bit appears as rom_addr[17].
- R5: A write to 0x40C0 stores the whole data byte, and gfx_bank follows bit 3 of the stored byte.
- R6: A read of 0x40C0 returns the stored byte on rd_data, and the byte becomes 0x00 on the edge that ends the read, so gfx_bank drops to 0.
- R7: After reset the position is 0, the page bit is 0, the status byte is 0xC0 and gfx_bank is 0.
- R8: A read of any address in 0x4080–0x40FF other than 0x40B0 and 0x40C0 returns 0xFF.
- R9: The position stays unchanged when the window is written, when the window address is held with no read strobe, and when any register is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | CPU address |
| bus_rd | input | 1 | Read strobe, one cycle for each access |
| bus_wr | input | 1 | Write strobe, one cycle for each access |
| bus_wdata | input | 8 | CPU write data |
| rd_data | output | 8 | Register read data (0x00 outside the register window) |
| rom_addr | output | 18 | Font ROM byte address |
| rom_rd | output | 1 | Marks a read of the font window |
| gfx_bank | output | 1 | 8 KiB graphics bank select |

## Verification
Long runs of window reads at a single glyph address pass the 31-to-0 wrap. These runs separate an adder that wraps at 32 from one that overflows into the glyph field. Window reads at random glyph addresses, mixed with rewinds, page writes, status writes and status reads, check that the glyph index, page bit and position each land in their own field. They also check that a rewind clears only the position. Idle cycles held on the window, and writes to the window, show whether the counter advances only on real reads. Back-to-back status reads tell a read that clears the byte apart from one that leaves it alone.

// File: rtl/glyph_pkg.sv
// Package: shared constants and the address-decode result type for the
// streaming glyph ROM address generator.
package glyph_pkg;

    localparam int GP_ADDR_W   = 16;
    localparam int GP_DATA_W   = 8;
    localparam int GP_POS_W    = 5;
    localparam int GP_GLYPH_W  = 12;

    localparam logic [GP_ADDR_W-1:0] GP_WIN_BASE  = 16'h5000;
    localparam logic [GP_ADDR_W-1:0] GP_REG_BASE  = 16'h4080;
    localparam int                   GP_REG_SPAN_W = 7;
    localparam logic [GP_ADDR_W-1:0] GP_PAGE_ADDR = 16'h40B0;
    localparam logic [GP_ADDR_W-1:0] GP_STAT_ADDR = 16'h40C0;

    localparam logic [GP_DATA_W-1:0] GP_STAT_INIT = 8'hC0;
    localparam int                   GP_GFX_BIT   = 3;

    // Which region an address falls in
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_WINDOW,
        SEL_PAGE,
        SEL_STAT,
        SEL_OTHER
    } region_e;

endpackage

// File: rtl/glyph_decode.sv
// Module: glyph_decode
// Purpose: sorts a CPU address into font window, page/rewind register,
// status register, other register-window address, or none.
// Assumes: both windows are aligned to their own size.
module glyph_decode
    import glyph_pkg::*;
#(
    parameter int                   ADDR_W     = GP_ADDR_W,
    parameter int                   WIN_SPAN_W = GP_GLYPH_W,
    parameter int                   REG_SPAN_W = GP_REG_SPAN_W,
    parameter logic [ADDR_W-1:0]    WIN_BASE   = GP_WIN_BASE,
    parameter logic [ADDR_W-1:0]    REG_BASE   = GP_REG_BASE,
    parameter logic [ADDR_W-1:0]    PAGE_ADDR  = GP_PAGE_ADDR,
    parameter logic [ADDR_W-1:0]    STAT_ADDR  = GP_STAT_ADDR
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region
);

    localparam int WIN_TAG_W = ADDR_W - WIN_SPAN_W;
    localparam int REG_TAG_W = ADDR_W - REG_SPAN_W;

    localparam logic [WIN_TAG_W-1:0] WIN_TAG = WIN_BASE[ADDR_W-1:WIN_SPAN_W];
    localparam logic [REG_TAG_W-1:0] REG_TAG = REG_BASE[ADDR_W-1:REG_SPAN_W];

    logic in_win;
    logic in_reg;

    // Compare the upper address bits against each window's tag
    always_comb begin
        in_win = (addr[ADDR_W-1:WIN_SPAN_W] == WIN_TAG);
        in_reg = (addr[ADDR_W-1:REG_SPAN_W] == REG_TAG);
    end

    // Pick the region, with the exact register addresses first
    always_comb begin
        if (in_win)                  region = SEL_WINDOW;
        else if (addr == PAGE_ADDR)  region = SEL_PAGE;
        else if (addr == STAT_ADDR)  region = SEL_STAT;
        else if (in_reg)             region = SEL_OTHER;
        else                         region = SEL_NONE;
    end

endmodule

// File: rtl/glyph_pos_counter.sv
// Module: glyph_pos_counter
// Purpose: the byte position within a glyph record. It advances modulo
// 2**POS_W and a rewind takes priority over an advance.
// Assumes: adv and rewind come from mutually exclusive decodes.
module glyph_pos_counter #(
    parameter int POS_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             rewind,
    output logic [POS_W-1:0] pos
);

    // Update the position: reset, rewind or natural wrap-around increment
    always_ff @(posedge clk) begin
        if (!rst_n)       pos <= '0;
        else if (rewind)  pos <= '0;
        else if (adv)     pos <= pos + POS_W'(1);
    end

endmodule

// File: rtl/glyph_regs.sv
// Module: glyph_regs
// Purpose: the page bit, the status byte that clears on read, and the
// read-data multiplexer for the register window.
// Assumes: rd and wr are never both high in one cycle.
module glyph_regs
    import glyph_pkg::*;
#(
    parameter int                 DATA_W    = GP_DATA_W,
    parameter logic [DATA_W-1:0]  STAT_INIT = GP_STAT_INIT,
    parameter int                 GFX_BIT   = GP_GFX_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  region_e           region,
    input  logic              rd,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              page,
    output logic [DATA_W-1:0] rd_data,
    output logic              gfx_bank
);

    localparam logic [DATA_W-1:0] ALL_ONES = '1;

    logic [DATA_W-1:0] stat_q;

    // Page bit: only data bit 0 of a page-register write is kept
    always_ff @(posedge clk) begin
        if (!rst_n)                          page <= 1'b0;
        else if (wr && region == SEL_PAGE)   page <= wdata[0];
    end

    // Status byte: loaded by a write, cleared by a read
    always_ff @(posedge clk) begin
        if (!rst_n)                          stat_q <= STAT_INIT;
        else if (wr && region == SEL_STAT)   stat_q <= wdata;
        else if (rd && region == SEL_STAT)   stat_q <= '0;
    end

    // Read data for the register window
    always_comb begin
        unique case (region)
            SEL_PAGE:  rd_data = '0;
            SEL_STAT:  rd_data = stat_q;
            SEL_OTHER: rd_data = ALL_ONES;
            default:   rd_data = '0;
        endcase
    end

    // Graphics bank select taken from the status byte
    always_comb gfx_bank = stat_q[GFX_BIT];

endmodule

// File: rtl/glyph_stream_reader.sv
// Module: glyph_stream_reader (top)
// Purpose: forms font ROM addresses from the glyph index in the CPU
// address and a position counter that streams through the record.
// Assumes: one-cycle read/write strobes, never both at once.
module glyph_stream_reader
    import glyph_pkg::*;
#(
    parameter int ADDR_W  = GP_ADDR_W,
    parameter int DATA_W  = GP_DATA_W,
    parameter int POS_W   = GP_POS_W,
    parameter int GLYPH_W = GP_GLYPH_W,
    parameter int ROM_AW  = 1 + GLYPH_W + POS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        rd_data,
    output logic [17:0]       rom_addr,
    output logic              rom_rd,
    output logic              gfx_bank
);

    region_e          region;
    logic [POS_W-1:0] pos;
    logic             page;
    logic             win_rd;
    logic             rewind;

    glyph_decode #(
        .ADDR_W     (ADDR_W),
        .WIN_SPAN_W (GLYPH_W)
    ) u_dec (
        .addr   (bus_addr),
        .region (region)
    );

    // Strobes qualified by region
    always_comb begin
        win_rd = bus_rd && (region == SEL_WINDOW);
        rewind = bus_rd && (region == SEL_PAGE);
    end

    glyph_pos_counter #(
        .POS_W (POS_W)
    ) u_pos (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (win_rd),
        .rewind (rewind),
        .pos    (pos)
    );

    glyph_regs #(
        .DATA_W (DATA_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .region   (region),
        .rd       (bus_rd),
        .wr       (bus_wr),
        .wdata    (bus_wdata),
        .page     (page),
        .rd_data  (rd_data),
        .gfx_bank (gfx_bank)
    );

    // ROM address: page bit, glyph index and position; shifting the index by
    // POS_W and adding a position below 2**POS_W is a concatenation
    always_comb begin
        rom_addr = ROM_AW'({page, bus_addr[GLYPH_W-1:0], pos});
        rom_rd   = win_rd;
    end

endmodule

// File: rtl/glyph_stream_reader_chk.sv
// Module: glyph_stream_reader_chk
// Purpose: temporal checks on the ports of glyph_stream_reader, attached
// through bind.
module glyph_stream_reader_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] bus_addr,
    input logic        bus_rd,
    input logic        bus_wr,
    input logic [7:0]  rd_data,
    input logic [17:0] rom_addr,
    input logic        rom_rd,
    input logic        gfx_bank
);

    logic page_rd;
    logic stat_rd;
    logic other_rd;

    always_comb begin
        page_rd  = bus_rd && bus_addr == 16'h40B0;
        stat_rd  = bus_rd && bus_addr == 16'h40C0;
        other_rd = bus_rd && bus_addr[15:7] == 9'h081 && !page_rd && !stat_rd;
    end

    // R2
    pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rom_rd |=> rom_addr[4:0] == $past(rom_addr[4:0]) + 5'd1);

    // R3
    rewind_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        page_rd |=> rom_addr[4:0] == 5'd0);

    // R3
    rewind_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        page_rd |-> rd_data == 8'h00);

    // R6
    stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> !gfx_bank);

    // R8
    other_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        other_rd |-> rd_data == 8'hFF);

    // R9
    pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr || (!bus_rd)) |=> $stable(rom_addr[4:0]));

endmodule

bind glyph_stream_reader glyph_stream_reader_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .rd_data  (rd_data),
    .rom_addr (rom_addr),
    .rom_rd   (rom_rd),
    .gfx_bank (gfx_bank)
);

// File: tb/sim_glyph_stream_reader.sv
module sim_glyph_stream_reader;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] bus_addr;
    logic        bus_rd;
    logic        bus_wr;
    logic [7:0]  bus_wdata;
    logic [7:0]  rd_data;
    logic [17:0] rom_addr;
    logic        rom_rd;
    logic        gfx_bank;

    int vecs = 0;
    int errs = 0;

    // Reference state
    int         m_pos  = 0;
    bit         m_page = 0;
    logic [7:0] m_stat = 8'hC0;

    always #5 clk = ~clk;

    glyph_stream_reader u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .rd_data   (rd_data),
        .rom_addr  (rom_addr),
        .rom_rd    (rom_rd),
        .gfx_bank  (gfx_bank)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit in_win(logic [15:0] a);
        return a[15:12] == 4'h5;
    endfunction

    function automatic bit in_regs(logic [15:0] a);
        return a[15:7] == 9'h081;
    endfunction

    function automatic logic [17:0] exp_rom(logic [15:0] a);
        return {m_page, a[11:0], 5'(m_pos)};
    endfunction

    function automatic logic [7:0] exp_rd(logic [15:0] a);
        if (in_win(a))          return 8'h00;
        if (a == 16'h40B0)      return 8'h00;
        if (a == 16'h40C0)      return m_stat;
        if (in_regs(a))         return 8'hFF;
        return 8'h00;
    endfunction

    // One read access with checks taken before the closing edge
    task automatic op_read(logic [15:0] a);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
        #2;
        chk("R5 gfx_bank", 32'(gfx_bank), 32'(m_stat[3]));
        chk("R1 rom_rd", 32'(rom_rd), 32'(in_win(a)));
        if (in_win(a)) chk("R1 rom_addr", 32'(rom_addr), 32'(exp_rom(a)));
        else if (a == 16'h40B0) chk("R3 rd_data", 32'(rd_data), 32'(exp_rd(a)));
        else if (a == 16'h40C0) chk("R6 rd_data", 32'(rd_data), 32'(exp_rd(a)));
        else chk("R8 rd_data", 32'(rd_data), 32'(exp_rd(a)));
        @(posedge clk);
        if (in_win(a))          m_pos = (m_pos + 1) % 32;
        else if (a == 16'h40B0) m_pos = 0;
        else if (a == 16'h40C0) m_stat = 8'h00;
        #1 bus_rd = 1'b0;
    endtask

    // One write access
    task automatic op_write(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
        @(posedge clk);
        if (a == 16'h40B0)      m_page = d[0];
        else if (a == 16'h40C0) m_stat = d;
        #1 bus_wr = 1'b0;
    endtask

    // Idle cycle with the window address held, then a position check
    task automatic op_idle(logic [15:0] a);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b0; bus_wr = 1'b0;
        @(negedge clk);
        #2 chk("R9 idle rom_addr", 32'(rom_addr), 32'(exp_rom(a)));
    endtask

    function automatic logic [15:0] rnd_win();
        return 16'h5000 | 16'($urandom_range(0, 4095));
    endfunction

    function automatic logic [15:0] rnd_other();
        logic [15:0] a;
        do a = 16'h4080 | 16'($urandom_range(0, 127));
        while (a == 16'h40B0 || a == 16'h40C0);
        return a;
    endfunction

    initial begin
        #2_000_000;
        errs++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        logic [15:0] g;
        void'($urandom(32'h5EED));
        rst_n = 1'b0; bus_addr = 16'h5000; bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #2;
        // R7 reset state
        chk("R7 rom_addr", 32'(rom_addr), 32'h0);
        chk("R7 gfx_bank", 32'(gfx_bank), 32'h0);
        op_read(16'h40C0); // R7: returns C0, then clears (R6)
        op_read(16'h40C0); // R6: second read returns 00

        // R2 wrap: 40 reads of one glyph
        g = 16'h5ABC;
        for (int i = 0; i < 40; i++) op_read(g);
        // R3 rewind mid-stream
        op_read(16'h40B0);
        op_read(g);
        // R4 upper data bits ignored, then page set
        op_write(16'h40B0, 8'hFE);
        op_read(16'h5FFF);
        op_write(16'h40B0, 8'h01);
        op_read(16'h5000);
        // R5 bank bit
        op_write(16'h40C0, 8'h08);
        op_read(16'h4081);
        op_write(16'h40C0, 8'hF7);
        op_read(16'h40C0);
        // R9 window write and idle do not advance
        op_write(16'h5123, 8'hAA);
        op_idle(16'h5123);
        op_write(16'h40C0, 8'h5A);
        op_idle(16'h5123);

        // Constrained random mix
        for (int i = 0; i < 600; i++) begin
            int k;
            k = $urandom_range(0, 99);
            if (k < 45)      op_read(rnd_win());
            else if (k < 52) op_read(16'h40B0);
            else if (k < 58) op_write(16'h40B0, 8'($urandom));
            else if (k < 66) op_write(16'h40C0, 8'($urandom));
            else if (k < 74) op_read(16'h40C0);
            else if (k < 84) op_read(rnd_other());
            else if (k < 92) op_write(rnd_win(), 8'($urandom));
            else             op_idle(rnd_win());
        end

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule